// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an eight-input, 8-bit successive-approximation converter. It selects one analog input through a multiplexer and holds the track-and-hold switch closed for a programmable number of conversion-clock periods. It then runs a binary search, one bit per conversion clock and most significant bit first. The search drives a trial code into an external DAC and reads back a single comparator bit. Finished codes go into a small bank of result registers that software reads.

Software picks one of four schedules. The first converts one input once. The second converts one input over and over. The third converts four adjacent inputs once. The fourth repeats that four-input scan. The conversion clock is a divided copy of the system clock. Both the divider and the track time come from configuration inputs. A sticky completion flag and a one-cycle interrupt pulse mark the end of each pass. A pass is either one conversion or a full four-input scan.

Top module: `adc_seq_top`

## Requirements
- R1: A start request is taken only when the sequencer is idle and `enable_i` is high. At that edge the schedule, base input and track length are captured, and `busy_o` is high from the next cycle. A start that arrives while busy, or while `enable_i` is low, has no effect.
- R2: While busy, one conversion-clock tick occurs every `clk_div_i`+1 system cycles. The count is continuous across inputs and passes.
- R3: Each conversion begins with a track phase. During that phase `sample_o` is high for `sh_cycles_i`+1 ticks, `ch_sel_o` is stable and `dac_code_o` is zero.
- R4: The search takes 8 ticks. The first trial code is 0x80. On each tick the current trial bit is kept when `cmp_i` is 1 (input at or above the code) and cleared otherwise, and the next lower bit is set. With a monotonic comparator the result equals the input level.
- R5: `mode_i` bit 0 selects a scan (1) or a single input (0). In single schedules only slot 0 (`result_o[7:0]`) is written, and the other slots keep their values.
- R6: A scan converts inputs base, base+1, base+2 and base+3, wrapping modulo 8, into slots 0 to 3. Slot k is held in `result_o[8k+7:8k]`.
- R7: At the edge that ends a pass, `done_o` is set and `irq_o` pulses for exactly one cycle. `done_o` stays high until the next accepted start clears it.
- R8: `mode_i` bit 1 selects a continuous schedule. A continuous schedule re-enters the track phase at slot 0 on the same edge that ends a pass, as long as `enable_i` is high. If `enable_i` is low at that edge, the sequencer goes idle.
- R9: After reset all outputs and all result slots are zero.
- R10: A pass takes (`sh_cycles_i`+9)·(`clk_div_i`+1) cycles per converted input, counted from the accepting edge to the edge that raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Software enable; permits start and continuous restart |
| start_i | input | 1 | Start request |
| mode_i | input | 2 | Bit 0 scan, bit 1 continuous |
| base_ch_i | input | 3 | First input of the pass |
| sh_cycles_i | input | 4 | Track length minus one, in ticks |
| clk_div_i | input | 4 | Conversion clock divider minus one |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC code |
| ch_sel_o | output | 3 | Multiplexer select |
| sample_o | output | 1 | Track-and-hold switch closed |
| dac_code_o | output | 8 | Trial code for the DAC |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | Sticky pass-complete flag |
| irq_o | output | 1 | One-cycle end-of-pass pulse |
| result_o | output | 32 | Four 8-bit result slots, slot 0 in the low byte |

## Verification
The final search step of a pass and the continuous restart land on the same edge. At that one edge the last slot is written, `done_o` and `irq_o` rise, and the sequencer jumps back into tracking at slot 0. A continuous scan provokes this. The bench checks that the gap between successive interrupts equals exactly four conversion times with no lost cycle, and that the value written in the last slot is correct. It also changes an input level between passes and checks that the second pass converts it afresh. Clearing the enable just before a pass ends must let that pass finish and then leave the sequencer idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRACK,
    ST_SEARCH
  } seq_state_e;

  localparam int unsigned MODE_SCAN_BIT = 0;
  localparam int unsigned MODE_CONT_BIT = 1;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // divider held constant while running
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && run_i) |=> !tick_o);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             begin_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic             fin_o,
  output logic [RES_W-1:0] value_o
);
  localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] trial_nxt;

  always_comb begin
    trial_nxt = trial_q;
    if (!cmp_i) trial_nxt[idx_q] = 1'b0;
    if (idx_q != '0) trial_nxt[idx_q - IDX_W'(1)] = 1'b1;
  end

  assign fin_o   = active_q && tick_i && (idx_q == '0);
  assign value_o = trial_nxt;
  assign code_o  = active_q ? trial_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      trial_q  <= '0;
    end else if (begin_i) begin
      active_q <= 1'b1;
      idx_q    <= IDX_W'(RES_W-1);
      trial_q  <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (active_q && tick_i) begin
      if (idx_q == '0) begin
        active_q <= 1'b0;
        trial_q  <= '0;
      end else begin
        idx_q   <= idx_q - 1'b1;
        trial_q <= trial_nxt;
      end
    end
  end

  p_msb_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    begin_i |=> code_o == {1'b1, {(RES_W-1){1'b0}}});
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [CH_W-1:0]   base_ch_i,
  input  logic [SH_W-1:0]   sh_cycles_i,
  input  logic              tick_i,
  input  logic              fin_i,
  output logic              busy_o,
  output logic              sample_o,
  output logic [CH_W-1:0]   ch_sel_o,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic              begin_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  seq_state_e        state_q;
  logic [SH_W-1:0]   sh_cnt_q, sh_lat_q;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        mode_q;
  logic [CH_W-1:0]   base_q;
  logic              done_q, irq_q;
  logic              last_slot;

  assign busy_o    = state_q != ST_IDLE;
  assign sample_o  = state_q == ST_TRACK;
  assign ch_sel_o  = base_q + CH_W'(slot_q);
  assign slot_o    = slot_q;
  assign begin_o   = sample_o && tick_i && (sh_cnt_q == sh_lat_q);
  assign last_slot = !mode_q[MODE_SCAN_BIT] || (slot_q == SLOT_W'(SLOTS-1));
  assign done_o    = done_q;
  assign irq_o     = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_cnt_q <= '0;
      sh_lat_q <= '0;
      slot_q   <= '0;
      mode_q   <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && enable_i) begin
          state_q  <= ST_TRACK;
          slot_q   <= '0;
          sh_cnt_q <= '0;
          mode_q   <= mode_i;
          base_q   <= base_ch_i;
          sh_lat_q <= sh_cycles_i;
          done_q   <= 1'b0;
        end
        ST_TRACK: if (tick_i) begin
          if (sh_cnt_q == sh_lat_q) begin
            state_q  <= ST_SEARCH;
            sh_cnt_q <= '0;
          end else begin
            sh_cnt_q <= sh_cnt_q + 1'b1;
          end
        end
        ST_SEARCH: if (fin_i) begin
          if (!last_slot) begin
            slot_q  <= slot_q + 1'b1;
            state_q <= ST_TRACK;
          end else begin
            slot_q  <= '0;
            done_q  <= 1'b1;
            irq_q   <= 1'b1;
            state_q <= (mode_q[MODE_CONT_BIT] && enable_i) ? ST_TRACK : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_start_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i && enable_i));
  p_ch_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(sample_o)) |-> $stable(ch_sel_o));
  p_fin_in_search_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |-> state_q == ST_SEARCH);
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned RES_W = 8,
  parameter int unsigned SLOTS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(SLOTS)-1:0] slot_i,
  input  logic [RES_W-1:0]         data_i,
  output logic [SLOTS*RES_W-1:0]   bank_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [RES_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (wr_i && slot_i == g[$clog2(SLOTS)-1:0]) q <= data_i;
    end
    assign bank_o[g*RES_W +: RES_W] = q;
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned RES_W = 8,
  parameter int unsigned SLOTS = 4,
  parameter int unsigned SH_W  = 4,
  parameter int unsigned DIV_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic                   start_i,
  input  logic [1:0]             mode_i,
  input  logic [CH_W-1:0]        base_ch_i,
  input  logic [SH_W-1:0]        sh_cycles_i,
  input  logic [DIV_W-1:0]       clk_div_i,
  input  logic                   cmp_i,
  output logic [CH_W-1:0]        ch_sel_o,
  output logic                   sample_o,
  output logic [RES_W-1:0]       dac_code_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   irq_o,
  output logic [SLOTS*RES_W-1:0] result_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic              tick, begin_conv, fin;
  logic [SLOT_W-1:0] slot;
  logic [RES_W-1:0]  value;

  adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(busy_o), .div_i(clk_div_i), .tick_o(tick)
  );

  adc_scan_ctrl #(.CH_W(CH_W), .SH_W(SH_W), .SLOTS(SLOTS)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .start_i, .mode_i, .base_ch_i, .sh_cycles_i,
    .tick_i(tick), .fin_i(fin), .busy_o, .sample_o, .ch_sel_o,
    .slot_o(slot), .begin_o(begin_conv), .done_o, .irq_o
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .begin_i(begin_conv), .tick_i(tick), .cmp_i,
    .code_o(dac_code_o), .fin_o(fin), .value_o(value)
  );

  adc_result_bank #(.RES_W(RES_W), .SLOTS(SLOTS)) u_bank (
    .clk_i, .rst_ni, .wr_i(fin), .slot_i(slot), .data_i(value), .bank_o(result_o)
  );

  p_track_dac_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> dac_code_o == '0);
  p_irq_sets_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  base = '0;
  logic [3:0]  sh = '0, dv = '0;
  logic        cmp;
  logic [2:0]  ch_sel;
  logic        sample, busy, done, irq;
  logic [7:0]  dac;
  logic [31:0] res;

  logic [7:0] vin [8];
  logic [7:0] exp_res [4];
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (dac <= vin[ch_sel]);

  adc_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .start_i(start),
    .mode_i(mode), .base_ch_i(base), .sh_cycles_i(sh), .clk_div_i(dv),
    .cmp_i(cmp), .ch_sel_o(ch_sel), .sample_o(sample), .dac_code_o(dac),
    .busy_o(busy), .done_o(done), .irq_o(irq), .result_o(res)
  );

  // mode[12:11] base[10:8] sh[7:4] div[3:0]
  localparam logic [12:0] VEC [6] = '{
    {2'b00, 3'd0, 4'd0, 4'd0},
    {2'b00, 3'd5, 4'd3, 4'd2},
    {2'b01, 3'd2, 4'd1, 4'd1},
    {2'b01, 3'd6, 4'd0, 4'd0},
    {2'b00, 3'd7, 4'd2, 4'd3},
    {2'b01, 3'd0, 4'd2, 4'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
  end

  task automatic wait_irq(output int lat, input int t0);
    int guard = 0;
    while (!irq && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    lat = cyc - t0;
  endtask

  task automatic check_bank(input string tag);
    for (int k = 0; k < 4; k++)
      check(res[k*8 +: 8] == exp_res[k], tag, res[k*8 +: 8], exp_res[k]);
  endtask

  task automatic run_pass(input logic [1:0] m, input logic [2:0] b,
                          input logic [3:0] s, input logic [3:0] d);
    int t0, lat, nin, samp, dac_bad, guard;
    nin = m[0] ? 4 : 1;
    @(negedge clk);
    mode = m; base = b; sh = s; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    check(done == 1'b0, "R7 done cleared by start", done, 0);
    samp = 0; dac_bad = 0; guard = 0;
    while (!irq && guard < 20000) begin
      if (sample) begin
        samp++;
        if (dac != 0) dac_bad++;
      end
      @(negedge clk);
      guard++;
    end
    lat = cyc - t0;
    check(lat == nin * (s + 9) * (d + 1), "R10 pass latency", lat, nin * (s + 9) * (d + 1));
    check(samp == nin * (s + 1) * (d + 1), "R3 track length", samp, nin * (s + 1) * (d + 1));
    check(dac_bad == 0, "R3 dac zero in track", dac_bad, 0);
    check(done == 1'b1, "R7 done set", done, 1);
    for (int k = 0; k < nin; k++) exp_res[k] = vin[(b + k) % 8];
    check_bank(m[0] ? "R6 scan slots" : "R5 single slot, R4 search");
    @(negedge clk);
    check(irq == 1'b0, "R7 irq one cycle", irq, 0);
    check(busy == 1'b0, "R8 one-shot goes idle", busy, 0);
  endtask

  initial begin
    int t0, lat;
    vin = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h55, 8'hAA, 8'h01, 8'hFE};
    for (int k = 0; k < 4; k++) exp_res[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busy == 0 && sample == 0 && done == 0 && irq == 0, "R9 reset flags", {busy, sample, done, irq}, 0);
    check(dac == 0 && ch_sel == 0 && res == 0, "R9 reset data", res, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 start ignored while enable low
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 start with enable low", busy, 0);
    enable = 1'b1;

    for (int v = 0; v < 6; v++)
      run_pass(VEC[v][12:11], VEC[v][10:8], VEC[v][7:4], VEC[v][3:0]);

    // R1 start while busy ignored
    @(negedge clk);
    mode = 2'b00; base = 3'd3; sh = 4'd2; dv = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; t0 = cyc;
    repeat (5) @(negedge clk);
    base = 3'd4; mode = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ch_sel == 3'd3, "R1 busy start keeps input", ch_sel, 3);
    wait_irq(lat, t0);
    check(lat == 11 * 2, "R1 busy start keeps timing", lat, 22);
    exp_res[0] = vin[3];
    check_bank("R1 busy start keeps slots");

    // R8 continuous scan: restart at same edge as pass end
    @(negedge clk);
    @(negedge clk);
    mode = 2'b11; base = 3'd4; sh = 4'd1; dv = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; t0 = cyc;
    wait_irq(lat, t0);
    check(lat == 4 * 10 * 2, "R8 first continuous pass", lat, 80);
    t0 = cyc;
    check(sample == 1'b1 && ch_sel == 3'd4, "R8 restart at slot 0", ch_sel, 4);
    vin[5] = 8'h3C;
    @(negedge clk);
    wait_irq(lat, t0);
    check(lat == 4 * 10 * 2, "R8 back-to-back gap", lat, 80);
    for (int k = 0; k < 4; k++) exp_res[k] = vin[(4 + k) % 8];
    check_bank("R8 second pass reconverts");
    t0 = cyc;
    enable = 1'b0;
    @(negedge clk);
    wait_irq(lat, t0);
    check(lat == 80, "R8 pass completes after disable", lat, 80);
    @(negedge clk);
    check(busy == 1'b0, "R8 idle after disable", busy, 0);

    // R2 continuous single with large divider
    enable = 1'b1;
    @(negedge clk);
    mode = 2'b10; base = 3'd1; sh = 4'd0; dv = 4'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0; t0 = cyc;
    wait_irq(lat, t0);
    check(lat == 9 * 8, "R2 divided tick rate", lat, 72);
    enable = 1'b0;
    t0 = cyc;
    @(negedge clk);
    wait_irq(lat, t0);
    exp_res[0] = vin[1];
    check_bank("R4 full-scale code");
    @(negedge clk);
    check(busy == 1'b0, "R8 single continuous stops", busy, 0);

    summary();
  end
endmodule